// File: doc/BRIEF.md
# Edge Counter and Capture Timer Channel

This block is one timer channel that watches a single asynchronous input pin and works in one of two capture modes. In count mode it counts qualifying edges on the pin. The number of edges to count is the difference between a load value and a match value. When that many edges have been seen, the channel raises a match status bit, returns its counter to the start value and disarms itself. Software must arm it again before it counts any more edges.

In time mode the same counter runs freely on every clock. At each qualifying edge its value is copied into a capture register, and an event status bit is set. The pin passes through a two-stage synchroniser. A 2-bit edge selector chooses rising edges, falling edges, both edges or none. The two status bits are sticky. Each bit is cleared by a one-cycle clear strobe. An interrupt line is the OR of the status bits that the mask enables. Configuration comes from the surrounding register block as plain ports.

Top module: `capture_timer`

## Requirements
- R1: After reset the channel is disarmed, `timer_val` reads all ones in count mode, both status bits are 0 and `irq` is low.
- R2: A change on `cap_pin` that is present at clock edge k is acted on at edge k+2. Counter and status change only after the third rising clock edge that follows the pin change.
- R3: `edge_sel` encodes 0 = rising edges, 1 = falling edges, 3 = both edges. Code 2 qualifies no edge.
- R4: A pulse on `arm` enables the channel and loads the start value. The start value is `match_val` when `count_up` is 1 and `load_val` when `count_up` is 0. `arm` overrides every other update in the same cycle.
- R5: In count mode (`time_mode` = 0) with the channel armed, each qualifying edge moves the counter by one: up when `count_up` is 1, down otherwise. `timer_val` shows the counter.
- R6: In count mode, the edge that brings the counter to the stop value does three things in the same cycle. It sets status bit 0 (match), reloads the start value and clears `enabled`. The stop value is `load_val` when counting up and `match_val` when counting down, so exactly `load_val - match_val` edges are counted. When counting up, `load_val` must be greater than `match_val`.
- R7: While `enabled` is 0, edges change neither the counter nor the status bits.
- R8: In time mode (`time_mode` = 1) with the channel armed, the counter steps by one on every clock in the `count_up` direction and wraps. On each qualifying edge the counter value of that cycle is latched, and `timer_val` shows the latch. The same edge sets status bit 1 (event).
- R9: Status bits are sticky. A 1 on `int_clr[i]` clears bit i. A set in the same cycle wins over the clear.
- R10: `irq` is high exactly when some status bit is set and its `int_mask` bit is 1.
- R11: `disarm` clears `enabled`. When `arm` and `disarm` are both high, the channel ends up armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| time_mode | input | 1 | 0 = edge count, 1 = edge time |
| count_up | input | 1 | Counter direction, 1 = up |
| edge_sel | input | 2 | Qualifying edge code |
| load_val | input | W | Interval load value |
| match_val | input | W | Match value |
| arm | input | 1 | Enable and load start value (pulse) |
| disarm | input | 1 | Disable channel (pulse) |
| int_mask | input | 2 | Interrupt enable per status bit |
| int_clr | input | 2 | Clear strobe per status bit |
| enabled | output | 1 | Channel armed |
| timer_val | output | W | Counter (count mode) or latched time (time mode) |
| raw_stat | output | 2 | Bit 0 match, bit 1 event |
| irq | output | 1 | Masked interrupt |

## Verification
The bench checks the synchroniser latency cycle by cycle. A design with one register too few or one too many would count an edge one clock early or one clock late. It counts down to the stop value and up to the stop value, and checks the reload and self-disarm that follow. A stop test that is off by one would count one edge too many or one too few, and a design that forgot to disarm would keep counting. It drives edges while the channel is disarmed and while the selector holds the reserved code; a design that leaked either would move the counter. In time mode it checks the exact latched value and the spacing between two captures, and it checks that `arm` wins over `disarm`.

// File: rtl/cap_timer_pkg.sv
// Shared types for the capture timer channel.
package cap_timer_pkg;
    // Qualifying-edge selector codes.
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_NONE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    // Status bit positions.
    localparam int ST_MATCH = 0;
    localparam int ST_EVENT = 1;
    localparam int ST_BITS  = 2;
endpackage

// File: rtl/cap_edge_detect.sv
// Synchronises the asynchronous pin through SYNC_STAGES flops.
// Emits a one-cycle pulse when the synchronised level makes the selected
// transition.
// Assumes the pin is low during reset and SYNC_STAGES >= 2.
module cap_edge_detect
    import cap_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_async,
    input  edge_sel_e sel,
    output logic      edge_hit
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   lvl_prev_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;

    assign lvl = chain_q[SYNC_STAGES-1];

    // Shift the pin through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q    <= '0;
            lvl_prev_q <= 1'b0;
        end else begin
            chain_q    <= {chain_q[SYNC_STAGES-2:0], pin_async};
            lvl_prev_q <= lvl;
        end
    end

    assign rise = lvl & ~lvl_prev_q;
    assign fall = ~lvl & lvl_prev_q;

    // Qualify the transition against the selector code.
    always_comb begin
        unique case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_BOTH: edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_count_core.sv
// One counter serves both modes.
// Count mode: steps on each qualified edge, then reloads and disarms at the
// stop value.
// Time mode: steps every clock and is latched into cap_q on each edge.
// Assumes configuration is stable while armed.
module cap_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         time_mode,
    input  logic         count_up,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    input  logic         arm,
    input  logic         disarm,
    input  logic         edge_hit,
    output logic         en_q,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cap_q,
    output logic         match_pulse,
    output logic         event_pulse
);
    logic [W-1:0] start_val;
    logic [W-1:0] stop_val;
    logic [W-1:0] step_val;

    assign start_val = count_up ? match_val : load_val;
    assign stop_val  = count_up ? load_val  : match_val;
    assign step_val  = count_up ? cnt_q + W'(1) : cnt_q - W'(1);

    assign match_pulse = !arm && en_q && !time_mode && edge_hit && (step_val == stop_val);
    assign event_pulse = !arm && en_q && time_mode && edge_hit;

    // Enable flag: arm sets it; disarm or a completed count clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  en_q <= 1'b0;
        else if (arm)                en_q <= 1'b1;
        else if (disarm || match_pulse) en_q <= 1'b0;
    end

    // Counter: load on arm, then step per edge or per clock by mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '1;
        else if (arm)                  cnt_q <= start_val;
        else if (en_q && time_mode)    cnt_q <= step_val;
        else if (en_q && edge_hit)     cnt_q <= match_pulse ? start_val : step_val;
    end

    // Capture latch: records the counter at each time-mode edge.
    always_ff @(posedge clk) begin
        if (!rst_n)           cap_q <= '0;
        else if (event_pulse) cap_q <= cnt_q;
    end
endmodule

// File: rtl/cap_irq_status.sv
// Sticky status bits with per-bit clear strobes and a masked interrupt.
// A set in the same cycle as a clear wins.
module cap_irq_status
    import cap_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ST_BITS-1:0] set,
    input  logic [ST_BITS-1:0] clr,
    input  logic [ST_BITS-1:0] mask,
    output logic [ST_BITS-1:0] raw,
    output logic               irq
);
    // One sticky flop per status bit.
    for (genvar i = 0; i < ST_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)      raw[i] <= 1'b0;
            else if (set[i]) raw[i] <= 1'b1;
            else if (clr[i]) raw[i] <= 1'b0;
        end
    end

    assign irq = |(raw & mask);
endmodule

// File: rtl/capture_timer.sv
// Top of the edge counter / capture timer channel.
// Ties the synchroniser, the counter core and the status logic together.
// Assumes configuration ports come from a register block and are changed
// only while the channel is disarmed.
module capture_timer
    import cap_timer_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_pin,
    input  logic         time_mode,
    input  logic         count_up,
    input  logic [1:0]   edge_sel,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] match_val,
    input  logic         arm,
    input  logic         disarm,
    input  logic [1:0]   int_mask,
    input  logic [1:0]   int_clr,
    output logic         enabled,
    output logic [W-1:0] timer_val,
    output logic [1:0]   raw_stat,
    output logic         irq
);
    logic               edge_hit;
    logic [W-1:0]       cnt_q;
    logic [W-1:0]       cap_q;
    logic               match_pulse;
    logic               event_pulse;
    logic [ST_BITS-1:0] set_vec;

    cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (cap_pin),
        .sel       (edge_sel_e'(edge_sel)),
        .edge_hit  (edge_hit)
    );

    cap_count_core #(.W(W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_mode   (time_mode),
        .count_up    (count_up),
        .load_val    (load_val),
        .match_val   (match_val),
        .arm         (arm),
        .disarm      (disarm),
        .edge_hit    (edge_hit),
        .en_q        (enabled),
        .cnt_q       (cnt_q),
        .cap_q       (cap_q),
        .match_pulse (match_pulse),
        .event_pulse (event_pulse)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[ST_MATCH] = match_pulse;
        set_vec[ST_EVENT] = event_pulse;
    end

    cap_irq_status u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (int_clr),
        .mask  (int_mask),
        .raw   (raw_stat),
        .irq   (irq)
    );

    assign timer_val = time_mode ? cap_q : cnt_q;
endmodule

// File: rtl/capture_timer_chk.sv
// Protocol checker for capture_timer, attached by bind.
module capture_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         time_mode,
    input logic         count_up,
    input logic [W-1:0] load_val,
    input logic [W-1:0] match_val,
    input logic         arm,
    input logic         disarm,
    input logic [1:0]   int_clr,
    input logic         enabled,
    input logic [1:0]   raw_stat,
    input logic [W-1:0] cnt_q,
    input logic [W-1:0] cap_q,
    input logic         match_pulse,
    input logic         event_pulse
);
    AST_MATCH_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !enabled); // R6
    AST_MATCH_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> cnt_q == ($past(count_up) ? $past(match_val) : $past(load_val))); // R6
    AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> raw_stat[0]); // R9
    AST_MATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[0] && !int_clr[0]) |=> raw_stat[0]); // R9
    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_stat[1] && !int_clr[1]) |=> raw_stat[1]); // R9
    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |=> cap_q == $past(cnt_q)); // R8
    AST_EVENT_TIME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        event_pulse |-> time_mode); // R8
    AST_MATCH_COUNT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> !time_mode); // R6
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_pulse, event_pulse})); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !arm) |=> $stable(cnt_q)); // R7
    AST_ARM_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> enabled); // R11
    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !arm) |=> !enabled); // R11
endmodule

bind capture_timer capture_timer_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_mode   (time_mode),
    .count_up    (count_up),
    .load_val    (load_val),
    .match_val   (match_val),
    .arm         (arm),
    .disarm      (disarm),
    .int_clr     (int_clr),
    .enabled     (enabled),
    .raw_stat    (raw_stat),
    .cnt_q       (cnt_q),
    .cap_q       (cap_q),
    .match_pulse (match_pulse),
    .event_pulse (event_pulse)
);

// File: tb/capture_timer_test.sv
`timescale 1ns/1ps
module capture_timer_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_pin = 1'b0;
    logic         time_mode = 1'b0;
    logic         count_up = 1'b0;
    logic [1:0]   edge_sel = 2'd0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] match_val = '0;
    logic         arm = 1'b0;
    logic         disarm = 1'b0;
    logic [1:0]   int_mask = 2'b00;
    logic [1:0]   int_clr = 2'b00;
    logic         enabled;
    logic [W-1:0] timer_val;
    logic [1:0]   raw_stat;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    capture_timer #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .time_mode(time_mode),
        .count_up(count_up), .edge_sel(edge_sel), .load_val(load_val),
        .match_val(match_val), .arm(arm), .disarm(disarm), .int_mask(int_mask),
        .int_clr(int_clr), .enabled(enabled), .timer_val(timer_val),
        .raw_stat(raw_stat), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    bit           hist[$];
    bit           m_en;
    int           m_cnt;
    int           m_cap;
    bit [1:0]     m_raw;
    localparam int MOD = 1 << W;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist  = '{0, 0, 0};
            m_en  = 0;
            m_cnt = MOD - 1;
            m_cap = 0;
            m_raw = 2'b00;
        end else begin
            bit lvl, prv, q, sm, se, en_old;
            int start, stop, nxt;
            lvl = hist[1];
            prv = hist[2];
            case (edge_sel)
                2'd0: q = lvl && !prv;
                2'd1: q = !lvl && prv;
                2'd3: q = lvl != prv;
                default: q = 0;
            endcase
            start  = count_up ? int'(match_val) : int'(load_val);
            stop   = count_up ? int'(load_val) : int'(match_val);
            nxt    = count_up ? (m_cnt + 1) % MOD : (m_cnt + MOD - 1) % MOD;
            sm     = 0;
            se     = 0;
            en_old = m_en;
            if (arm) begin
                m_en  = 1;
                m_cnt = start;
            end else begin
                if (disarm) m_en = 0;
                if (en_old && time_mode) begin
                    if (q) begin m_cap = m_cnt; se = 1; end
                    m_cnt = nxt;
                end else if (en_old && q) begin
                    if (nxt == stop) begin
                        m_cnt = start; sm = 1; m_en = 0;
                    end else m_cnt = nxt;
                end
            end
            m_raw = (m_raw & ~int_clr) | {se, sm};
            void'(hist.pop_back());
            hist.push_front(cap_pin);
        end
    end

    // Compare the design with the model after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            int exp_tv;
            exp_tv = time_mode ? m_cap : m_cnt;
            check(enabled == m_en, "R11 enabled", int'(enabled), int'(m_en));
            check(int'(timer_val) == exp_tv, "R5 timer_val", int'(timer_val), exp_tv);
            check(raw_stat == m_raw, "R9 raw_stat", int'(raw_stat), int'(m_raw));
            check(irq == |(m_raw & int_mask), "R10 irq", int'(irq), int'(|(m_raw & int_mask)));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        arm = 1'b1; step(1); arm = 1'b0;
    endtask

    task automatic pin_pulse();
        cap_pin = 1'b1; step(4); cap_pin = 1'b0; step(4);
    endtask

    task automatic clear_all();
        int_clr = 2'b11; step(1); int_clr = 2'b00;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v1, v2;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check(enabled == 1'b0, "R1 enabled", int'(enabled), 0);
        check(timer_val == '1, "R1 timer_val", int'(timer_val), MOD - 1);
        check(raw_stat == 2'b00 && irq == 1'b0, "R1 status", int'(raw_stat), 0);

        // Count down by rising edges: 5 -> 2, three edges
        load_val = 16'd5; match_val = 16'd2; count_up = 1'b0; edge_sel = 2'd0;
        do_arm();
        check(timer_val == 16'd5 && enabled, "R4 start down", int'(timer_val), 5);
        pin_pulse();
        check(timer_val == 16'd4, "R5 one edge down", int'(timer_val), 4);
        pin_pulse();
        pin_pulse();
        check(raw_stat[0] == 1'b1, "R6 match set", int'(raw_stat[0]), 1);
        check(timer_val == 16'd5, "R6 reload", int'(timer_val), 5);
        check(enabled == 1'b0, "R6 disarmed", int'(enabled), 0);
        check(irq == 1'b0, "R10 masked off", int'(irq), 0);
        int_mask = 2'b01; step(1);
        check(irq == 1'b1, "R10 mask on", int'(irq), 1);
        pin_pulse();
        check(timer_val == 16'd5, "R7 idle edge", int'(timer_val), 5);
        clear_all();
        check(raw_stat == 2'b00 && irq == 1'b0, "R9 cleared", int'(raw_stat), 0);

        // R2 synchroniser latency
        load_val = 16'd20; match_val = 16'd0;
        do_arm();
        cap_pin = 1'b1;
        @(posedge clk); @(posedge clk); #2;
        check(timer_val == 16'd20, "R2 not yet", int'(timer_val), 20);
        @(posedge clk); #2;
        check(timer_val == 16'd19, "R2 third edge", int'(timer_val), 19);
        @(negedge clk);
        cap_pin = 1'b0; step(4);

        // Count up by falling edges: 7 -> 10
        disarm = 1'b1; step(1); disarm = 1'b0;
        load_val = 16'd10; match_val = 16'd7; count_up = 1'b1; edge_sel = 2'd1;
        do_arm();
        check(timer_val == 16'd7, "R4 start up", int'(timer_val), 7);
        cap_pin = 1'b1; step(4);
        check(timer_val == 16'd7, "R3 rise ignored", int'(timer_val), 7);
        cap_pin = 1'b0; step(4);
        check(timer_val == 16'd8, "R3 fall counted", int'(timer_val), 8);
        edge_sel = 2'd3;
        pin_pulse();
        check(raw_stat[0] == 1'b1 && timer_val == 16'd7 && !enabled, "R6 up stop",
              int'(timer_val), 7);
        clear_all();
        edge_sel = 2'd2;
        do_arm();
        pin_pulse();
        check(timer_val == 16'd7 && raw_stat == 2'b00, "R3 code 2 inert", int'(timer_val), 7);

        // R11 arm wins over disarm
        arm = 1'b1; disarm = 1'b1; step(1); arm = 1'b0; disarm = 1'b0;
        check(enabled == 1'b1, "R11 arm wins", int'(enabled), 1);
        disarm = 1'b1; step(1); disarm = 1'b0;
        check(enabled == 1'b0, "R11 disarm", int'(enabled), 0);

        // Time mode, both edges, counting up from 100
        time_mode = 1'b1; edge_sel = 2'd3; match_val = 16'd100; int_mask = 2'b10;
        do_arm();
        cap_pin = 1'b1; step(4);
        v1 = int'(timer_val);
        check(v1 == 102, "R8 first capture", v1, 102);
        check(raw_stat[1] == 1'b1 && irq == 1'b1, "R8 event status", int'(raw_stat), 2);
        cap_pin = 1'b0; step(4);
        v2 = int'(timer_val);
        check(v2 - v1 == 4, "R8 capture spacing", v2 - v1, 4);
        int_clr = 2'b10; step(1); int_clr = 2'b00;
        check(raw_stat[1] == 1'b0, "R9 event cleared", int'(raw_stat[1]), 0);
        // Hold the clear while an edge arrives: the set wins in its cycle
        int_clr = 2'b10;
        pin_pulse();
        int_clr = 2'b00;
        disarm = 1'b1; step(1); disarm = 1'b0;
        step(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule